// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two 16-bit tri-state buses, A and B. Each transfer direction has its own capture register. The A-to-B register samples bus A on a rising edge of its own clock. The B-to-A register samples bus B on a rising edge of a second clock. When the block drives a bus, a select input for that direction chooses the source. The source is either the live value on the opposite bus, passed straight through, or the value held in that direction's register.

An active-low enable and a direction input decide which bus the block drives. With the enable high, both buses float and the block is isolated. The registers keep capturing in that state. With the enable low and the direction input high, the block drives B and treats A as its input. With the direction input low, it drives A and treats B as its input.

The 16 bits form two independent 8-bit lanes. Each lane has its own two clocks, two selects, enable and direction. One lane's controls never affect the other lane's bits. The registers have no reset. They change only on their own clock edges, whatever the enable and direction inputs are doing.

Top module: `rtbus_xcvr`

## Requirements
- R1: A rising edge on `clk_ab[l]` loads the current lane-l bits of bus A into that lane's A-to-B register. This applies in every mode, including while the block drives B.
- R2: A rising edge on `clk_ba[l]` loads the current lane-l bits of bus B into that lane's B-to-A register. This applies in every mode.
- R3: While `oe_n[l]` is 1, the block drives neither bus in lane l. An undriven bus shows only its external pull value.
- R4: While `oe_n[l]` is 0 and `dir[l]` is 1, the block drives lane l of bus B and leaves lane l of bus A undriven.
- R5: While `oe_n[l]` is 0 and `dir[l]` is 0, the block drives lane l of bus A and leaves lane l of bus B undriven.
- R6: While B is driven and `sel_ab[l]` is 0, lane l of B equals lane l of A. The path is combinational, so B follows a change on A with no clock edge.
- R7: While B is driven and `sel_ab[l]` is 1, lane l of B equals the A-to-B register content.
- R8: While A is driven, lane l of A equals the live lane-l bits of B when `sel_ba[l]` is 0. It equals the B-to-A register content when `sel_ba[l]` is 1.
- R9: In transceiver mode, the value on the input bus can be captured into both registers. For example, with B driven from live A, a `clk_ba` edge stores the A value carried on B.
- R10: While `oe_n[l]` is 1, edges on `clk_ab[l]` and `clk_ba[l]` still capture bus A and bus B respectively. The two edges act independently.
- R11: Controls and clocks of one lane leave the other lane's bits and registers unchanged.
- R12: With no edge on a lane's clocks, its register contents are unchanged by changes on `oe_n`, `dir`, the selects or the bus data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_a | inout | 16 | Bus A, two 8-bit lanes; input, or tri-state output |
| bus_b | inout | 16 | Bus B, two 8-bit lanes; input, or tri-state output |
| clk_ab | input | 2 | Per-lane capture clock for the A-to-B register, rising edge |
| clk_ba | input | 2 | Per-lane capture clock for the B-to-A register, rising edge |
| sel_ab | input | 2 | Per-lane source for B: 0 live A, 1 stored register |
| sel_ba | input | 2 | Per-lane source for A: 0 live B, 1 stored register |
| oe_n | input | 2 | Per-lane output enable, active low; 1 isolates both buses |
| dir | input | 2 | Per-lane direction when enabled: 1 drives B, 0 drives A |

## Verification
Live-path and drive-enable results are combinational. The bench samples them a few nanoseconds after it changes an input, without waiting for a clock. That includes re-checking B one nanosecond after A changes, which shows the pass-through does not wait for an edge. Stored results become visible right after the rising edge of the capture pulse. Every capture pulse finishes with a settle delay before any read.

The bench models bus A with pull-ups and bus B with pull-downs. A floating lane therefore reads all ones on A and all zeros on B, and the bench uses this to prove the block is not driving. The bench drives a bus externally only when that bus is the block's input or the lane is isolated. The idle lane is checked against its pull values after every sequence run on the other lane.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned LANE_BITS = 8;

  // Which bus, if any, a lane drives
  typedef enum logic [1:0] {
    DRV_NONE = 2'd0,
    DRV_A    = 2'd1,
    DRV_B    = 2'd2
  } drive_e;
endpackage

// File: rtl/xcvr_drive_dec.sv
module xcvr_drive_dec
  import xcvr_pkg::*;
(
  input  logic   oe_n,
  input  logic   dir,
  output drive_e mode
);
  always_comb begin
    if (oe_n)     mode = DRV_NONE;
    else if (dir) mode = DRV_B;
    else          mode = DRV_A;
  end
endmodule

// File: rtl/xcvr_cap_reg.sv
module xcvr_cap_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  // No reset: content changes only on a rising clock edge
  always_ff @(posedge clk) begin
    q <= d;
  end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int unsigned LW = 8
) (
  inout  wire  [LW-1:0] a_io,
  inout  wire  [LW-1:0] b_io,
  input  logic          clk_ab,
  input  logic          clk_ba,
  input  logic          sel_ab,
  input  logic          sel_ba,
  input  logic          oe_n,
  input  logic          dir
);
  logic [LW-1:0] a_in, b_in;
  logic [LW-1:0] reg_ab, reg_ba;
  logic [LW-1:0] a_drv, b_drv;
  drive_e        mode;

  assign a_in = a_io;
  assign b_in = b_io;

  xcvr_drive_dec u_dec (
    .oe_n (oe_n),
    .dir  (dir),
    .mode (mode)
  );

  xcvr_cap_reg #(.WIDTH(LW)) u_reg_ab (
    .clk (clk_ab),
    .d   (a_in),
    .q   (reg_ab)
  );

  xcvr_cap_reg #(.WIDTH(LW)) u_reg_ba (
    .clk (clk_ba),
    .d   (b_in),
    .q   (reg_ba)
  );

  assign b_drv = sel_ab ? reg_ab : a_in;
  assign a_drv = sel_ba ? reg_ba : b_in;

  assign b_io = (mode == DRV_B) ? b_drv : {LW{1'bz}};
  assign a_io = (mode == DRV_A) ? a_drv : {LW{1'bz}};

  // Checks sampled at capture edges, where bus values have settled
  always @(posedge clk_ab) begin
    // R3
    iso_chk: assert (!oe_n || mode == DRV_NONE)
      else $error("lane driving while isolated");
    // R4
    dir_b_chk: assert (oe_n || !dir || mode == DRV_B)
      else $error("B not selected for drive");
    // R6
    live_b_chk: assert (!(mode == DRV_B && !sel_ab) || b_io == a_io)
      else $error("B does not follow live A");
    // R7
    stored_b_chk: assert (!(mode == DRV_B && sel_ab) || b_io == reg_ab)
      else $error("B does not show stored A-to-B value");
  end

  always @(posedge clk_ba) begin
    // R5
    dir_a_chk: assert (oe_n || dir || mode == DRV_A)
      else $error("A not selected for drive");
    // R8
    src_a_chk: assert (mode != DRV_A || a_io == (sel_ba ? reg_ba : b_io))
      else $error("A source mismatch");
  end
endmodule

// File: rtl/rtbus_xcvr.sv
module rtbus_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned LW    = LANE_BITS
) (
  inout  wire  [WIDTH-1:0]    bus_a,
  inout  wire  [WIDTH-1:0]    bus_b,
  input  logic [WIDTH/LW-1:0] clk_ab,
  input  logic [WIDTH/LW-1:0] clk_ba,
  input  logic [WIDTH/LW-1:0] sel_ab,
  input  logic [WIDTH/LW-1:0] sel_ba,
  input  logic [WIDTH/LW-1:0] oe_n,
  input  logic [WIDTH/LW-1:0] dir
);
  localparam int unsigned LANES = WIDTH / LW;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    xcvr_lane #(.LW(LW)) u_lane (
      .a_io   (bus_a[l*LW +: LW]),
      .b_io   (bus_b[l*LW +: LW]),
      .clk_ab (clk_ab[l]),
      .clk_ba (clk_ba[l]),
      .sel_ab (sel_ab[l]),
      .sel_ba (sel_ba[l]),
      .oe_n   (oe_n[l]),
      .dir    (dir[l])
    );
  end
endmodule

// File: tb/tb_rtbus_xcvr.sv
`timescale 1ns/1ps
module tb_rtbus_xcvr;
  localparam int W = 16;
  localparam int LW = 8;
  localparam int NL = W / LW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  tri1 [W-1:0] bus_a;
  tri0 [W-1:0] bus_b;
  logic [NL-1:0] ea_en, eb_en;
  logic [W-1:0]  ea_val, eb_val;
  logic [NL-1:0] clk_ab, clk_ba, sel_ab, sel_ba, oe_n, dir;

  for (genvar l = 0; l < NL; l++) begin : g_ext
    assign bus_a[l*LW +: LW] = ea_en[l] ? ea_val[l*LW +: LW] : {LW{1'bz}};
    assign bus_b[l*LW +: LW] = eb_en[l] ? eb_val[l*LW +: LW] : {LW{1'bz}};
  end

  rtbus_xcvr dut (
    .bus_a(bus_a), .bus_b(bus_b), .clk_ab(clk_ab), .clk_ba(clk_ba),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .oe_n(oe_n), .dir(dir)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rd_a(input int l);
    return bus_a[l*LW +: LW];
  endfunction
  function automatic logic [7:0] rd_b(input int l);
    return bus_b[l*LW +: LW];
  endfunction

  task automatic pulse_ab(input int l);
    clk_ab[l] = 1'b1; #5; clk_ab[l] = 1'b0; #5;
  endtask
  task automatic pulse_ba(input int l);
    clk_ba[l] = 1'b1; #5; clk_ba[l] = 1'b0; #5;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    ea_en = '0; eb_en = '0; ea_val = '0; eb_val = '0;
    clk_ab = '0; clk_ba = '0; sel_ab = '0; sel_ba = '0;
    oe_n = '1; dir = '0;
    #15;
    // Reset-free start: isolated lanes show pulls
    for (int l = 0; l < NL; l++) begin
      chk("R3 start A", rd_a(l), 8'hFF);
      chk("R3 start B", rd_b(l), 8'h00);
    end

    for (int l = 0; l < NL; l++) begin
      for (int i = 0; i < 16; i++) begin
        automatic int o = NL - 1 - l;
        automatic logic [7:0] a = 8'((i * 53 + 17) & 255);
        automatic logic [7:0] b = 8'((i * 29 + 200) & 255);
        automatic logic [7:0] c = ~a;
        automatic logic [7:0] c2 = c ^ 8'h5A;
        automatic logic [7:0] d = 8'((i * 71 + 3) & 255);
        @(negedge clk);
        // Isolation capture, R10
        oe_n[l] = 1'b1;
        ea_val[l*LW +: LW] = a; eb_val[l*LW +: LW] = b;
        ea_en[l] = 1'b1; eb_en[l] = 1'b1; #5;
        pulse_ab(l); pulse_ba(l);
        ea_en[l] = 1'b0; eb_en[l] = 1'b0; #5;
        chk("R3 iso A", rd_a(l), 8'hFF);
        chk("R3 iso B", rd_b(l), 8'h00);
        // Stored A-to-B on B, R1 R7 R10
        sel_ab[l] = 1'b1; dir[l] = 1'b1; oe_n[l] = 1'b0; #5;
        chk("R7 R10 stored B", rd_b(l), a);
        chk("R4 A undriven", rd_a(l), 8'hFF);
        // Stored B-to-A on A, R2 R8
        sel_ba[l] = 1'b1; dir[l] = 1'b0; #5;
        chk("R8 R2 stored A", rd_a(l), b);
        chk("R5 B undriven", rd_b(l), 8'h00);
        // Hold without edges, R12
        oe_n[l] = 1'b1; sel_ab[l] = 1'b0; #5;
        eb_val[l*LW +: LW] = d; eb_en[l] = 1'b1; #5; eb_en[l] = 1'b0;
        sel_ab[l] = 1'b1; dir[l] = 1'b1; oe_n[l] = 1'b0; #5;
        chk("R12 hold B", rd_b(l), a);
        // Live A to B, R6
        sel_ab[l] = 1'b0;
        ea_val[l*LW +: LW] = c; ea_en[l] = 1'b1; #5;
        chk("R6 live B", rd_b(l), c);
        ea_val[l*LW +: LW] = c2; #1;
        chk("R6 live B follows", rd_b(l), c2);
        #4;
        // Capture in transceiver mode into both registers, R9 R1
        pulse_ab(l); pulse_ba(l);
        ea_en[l] = 1'b0;
        sel_ba[l] = 1'b1; dir[l] = 1'b0; #5;
        chk("R9 BA got live", rd_a(l), c2);
        sel_ab[l] = 1'b1; dir[l] = 1'b1; #5;
        chk("R1 AB captured", rd_b(l), c2);
        // Live B to A, R8
        dir[l] = 1'b0; sel_ba[l] = 1'b0;
        eb_val[l*LW +: LW] = d; eb_en[l] = 1'b1; #5;
        chk("R8 live A", rd_a(l), d);
        eb_en[l] = 1'b0; oe_n[l] = 1'b1; #5;
        // Other lane untouched, R11
        chk("R11 other A", rd_a(o), 8'hFF);
        chk("R11 other B", rd_b(o), 8'h00);
      end
      // Other lane registers unchanged by this lane, R11
      begin
        automatic int o = NL - 1 - l;
        automatic logic [7:0] a = 8'((15 * 53 + 17) & 255);
        automatic logic [7:0] b = 8'((15 * 29 + 200) & 255);
        if (l == 1) begin
          sel_ab[o] = 1'b1; dir[o] = 1'b1; oe_n[o] = 1'b0; #5;
          chk("R11 other reg AB", rd_b(o), ~a ^ 8'h5A);
          oe_n[o] = 1'b1; #5;
        end
        sel_ba[l] = 1'b1; dir[l] = 1'b0; oe_n[l] = 1'b0; #5;
        chk("R12 final BA", rd_a(l), ~a ^ 8'h5A);
        oe_n[l] = 1'b1; #5;
        if (b == 8'h00) chk("R3 spare", rd_b(l), 8'h00);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule